// File: doc/BRIEF.md
# Timestamp Counter with Selectable Timebase

This block keeps a free-running timestamp that advances in physical time units rather than in system clock cycles. Software picks the unit through a small configuration register: nanoseconds (advanced in 20 ns steps), microseconds or milliseconds. The count can be read at any time through a simple register port, and it wraps silently when it reaches the top of its range.

Internally a five-state controller follows the configuration. `ST_RUN_NS`, `ST_RUN_US` and `ST_RUN_MS` let a shared prescaler produce increments at the selected rate. `ST_STOPPED` freezes the count when an unsupported source code is stored. `ST_HELD` clamps the count to zero while the clear bit is set. The controller only moves on a configuration write, and then it goes to the state that the written value decodes to. The decode rule is: clear bit set goes to `ST_HELD`; otherwise source 0 goes to `ST_RUN_NS`, 1 to `ST_RUN_US`, 2 to `ST_RUN_MS`, and any other value to `ST_STOPPED`. Without a write the state holds. To zero the timestamp, write the current source with the clear bit set, then write the same source again with the bit clear.

The system clock frequency is a parameter (`CLK_HZ`, a whole multiple of 50 MHz), and the prescaler limits are derived from it.

Top module: `tsc_timestamp`

## Requirements
- R1: After power-on reset the configuration reads 0 and the count reads 0. The block starts in `ST_RUN_NS`, so the count reaches 40 ten cycles after reset release at 250 MHz.
- R2: The configuration register is at offset 0x600 and the count register is at offset 0x602. Configuration bits 7:0 are the source code and bit 8 is the clear bit. Configuration bits 31:9 read as zero, and any other address reads zero.
- R3: While the clear bit is set, the count reads 0. After the same source is written with bit 8 clear, counting resumes from 0.
- R4: With source 0, the count grows by 20 once every CLK_HZ/50,000,000 cycles (every 20 ns).
- R5: With source 1, the count grows by 1 once every CLK_HZ/1,000,000 cycles.
- R6: With source 2, the count grows by 1 once every CLK_HZ/1,000 cycles.
- R7: A source code above 2 freezes the count at its current value, and the stored code reads back unchanged.
- R8: Every configuration write restarts the prescaler, so the first increment comes one full period after the write edge.
- R9: A write to the count register changes neither the count nor the configuration.
- R10: The count wraps modulo 2^COUNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at CLK_HZ |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |

## Verification
The assertions assume that `bus_wr` is a clean single-cycle strobe whose address and data are stable around the sampling edge. They also assume that `CLK_HZ` is a whole multiple of 50 MHz, so every prescaler limit is an integer of at least one. The bench changes bus signals only on falling edges, with strobes that last exactly one cycle. It runs the main instance at 250 MHz. It uses a second instance with 50 MHz scaling and an 8-bit count, so that the millisecond rate and the wrap point can be reached within a short run.

// File: rtl/tsc_pkg.sv
`timescale 1ns/1ps
package tsc_pkg;
    localparam int SRC_W   = 8;
    localparam int CLR_BIT = 8;
    localparam int CFG_W   = 9;

    typedef enum logic [2:0] {
        ST_RUN_NS  = 3'd0,
        ST_RUN_US  = 3'd1,
        ST_RUN_MS  = 3'd2,
        ST_STOPPED = 3'd3,
        ST_HELD    = 3'd4
    } tsc_state_e;

    // Map a configuration word onto the controller state it selects.
    function automatic tsc_state_e cfg_to_state(input logic [CFG_W-1:0] cfg);
        tsc_state_e st;
        if (cfg[CLR_BIT]) begin
            st = ST_HELD;
        end else begin
            case (cfg[SRC_W-1:0])
                8'd0:    st = ST_RUN_NS;
                8'd1:    st = ST_RUN_US;
                8'd2:    st = ST_RUN_MS;
                default: st = ST_STOPPED;
            endcase
        end
        return st;
    endfunction
endpackage

// File: rtl/tsc_cfg_regs.sv
`timescale 1ns/1ps
module tsc_cfg_regs
    import tsc_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int CFG_OFS = 'h600
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [CFG_W-1:0]  cfg_q,
    output logic [CFG_W-1:0]  cfg_next,
    output logic              cfg_wr
);
    localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(CFG_OFS);

    logic unused_hi;
    assign unused_hi = ^bus_wdata[31:CFG_W];

    assign cfg_wr   = bus_wr && (bus_addr == CFG_A);
    assign cfg_next = cfg_wr ? bus_wdata[CFG_W-1:0] : cfg_q;

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_next;
    end

    // R2
    cfg_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == CFG_A) |=> cfg_q == $past(bus_wdata[CFG_W-1:0]));
endmodule

// File: rtl/tsc_timebase.sv
`timescale 1ns/1ps
module tsc_timebase
    import tsc_pkg::*;
#(
    parameter longint CLK_HZ = 250_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_next,
    output logic             tick,
    output logic             clr,
    output logic             step20
);
    localparam longint NS_DIV = CLK_HZ / 50_000_000;
    localparam longint US_DIV = CLK_HZ / 1_000_000;
    localparam longint MS_DIV = CLK_HZ / 1_000;
    localparam int     PRE_W  = $clog2(MS_DIV + 1);
    localparam logic [PRE_W-1:0] NS_LIM = PRE_W'(NS_DIV - 1);
    localparam logic [PRE_W-1:0] US_LIM = PRE_W'(US_DIV - 1);
    localparam logic [PRE_W-1:0] MS_LIM = PRE_W'(MS_DIV - 1);

    tsc_state_e       state_q, state_d;
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] lim;
    logic             running;

    // State register: moves only on a configuration write.
    assign state_d = cfg_wr ? cfg_to_state(cfg_next) : state_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN_NS;
        else        state_q <= state_d;
    end

    // Outputs of the state machine.
    always_comb begin
        running = 1'b0;
        lim     = MS_LIM;
        step20  = 1'b0;
        unique case (state_q)
            ST_RUN_NS:  begin running = 1'b1; lim = NS_LIM; step20 = 1'b1; end
            ST_RUN_US:  begin running = 1'b1; lim = US_LIM; end
            ST_RUN_MS:  begin running = 1'b1; lim = MS_LIM; end
            ST_STOPPED: running = 1'b0;
            ST_HELD:    running = 1'b0;
            default:    running = 1'b0;
        endcase
    end

    assign tick = running && (pre_q == lim) && !cfg_wr;
    assign clr  = (state_d == ST_HELD);

    always_ff @(posedge clk) begin
        if (!rst_n)                   pre_q <= '0;
        else if (cfg_wr || !running)  pre_q <= '0;
        else if (pre_q == lim)        pre_q <= '0;
        else                          pre_q <= pre_q + 1'b1;
    end

    // R8
    pre_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> pre_q == '0);
    // R6
    pre_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= MS_LIM);
    // R7
    stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOPPED && !cfg_wr) |=> pre_q == '0);
endmodule

// File: rtl/tsc_counter.sv
`timescale 1ns/1ps
module tsc_counter #(
    parameter int COUNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               tick,
    input  logic               step20,
    output logic [COUNT_W-1:0] count_q
);
    logic [COUNT_W-1:0] step;
    assign step = step20 ? COUNT_W'(20) : COUNT_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n)     count_q <= '0;
        else if (clr)   count_q <= '0;
        else if (tick)  count_q <= count_q + step;
    end

    // R3
    hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count_q == '0);
    // R9
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !tick) |=> $stable(count_q));
    // R4
    ns_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr && step20) |=> count_q == $past(count_q) + COUNT_W'(20));
endmodule

// File: rtl/tsc_timestamp.sv
`timescale 1ns/1ps
module tsc_timestamp
    import tsc_pkg::*;
#(
    parameter longint CLK_HZ  = 250_000_000,
    parameter int     COUNT_W = 32,
    parameter int     ADDR_W  = 12,
    parameter int     CFG_OFS = 'h600,
    parameter int     CNT_OFS = 'h602
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);
    localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(CFG_OFS);
    localparam logic [ADDR_W-1:0] CNT_A = ADDR_W'(CNT_OFS);

    logic [CFG_W-1:0]   cfg_q, cfg_next;
    logic               cfg_wr, tick, clr, step20;
    logic [COUNT_W-1:0] count_q;

    tsc_cfg_regs #(.ADDR_W(ADDR_W), .CFG_OFS(CFG_OFS)) regs_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .cfg_q(cfg_q), .cfg_next(cfg_next), .cfg_wr(cfg_wr)
    );

    tsc_timebase #(.CLK_HZ(CLK_HZ)) tb_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_next(cfg_next),
        .tick(tick), .clr(clr), .step20(step20)
    );

    tsc_counter #(.COUNT_W(COUNT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick), .step20(step20),
        .count_q(count_q)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CFG_A)      bus_rdata[CFG_W-1:0]   = cfg_q;
        else if (bus_addr == CNT_A) bus_rdata[COUNT_W-1:0] = count_q;
    end

    // R9
    cnt_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == CNT_A) |=> $stable(cfg_q));
endmodule

// File: tb/tsc_timestamp_tb.sv
`timescale 1ns/1ps
module tsc_timestamp_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata_m, rdata_s;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    localparam logic [11:0] A_CFG = 12'h600;
    localparam logic [11:0] A_CNT = 12'h602;

    always #2 clk = ~clk;

    tsc_timestamp dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_m)
    );

    tsc_timestamp #(.CLK_HZ(50_000_000), .COUNT_W(8)) dut_small_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_s)
    );

    // {source[7:0], wait cycles[23:0], expected count[31:0]} for the 250 MHz instance
    localparam int NV = 8;
    localparam logic [63:0] VECS [NV] = '{
        {8'd0,   24'd23,   32'd80},   // R4
        {8'd0,   24'd4,    32'd0},    // R4
        {8'd0,   24'd5,    32'd20},   // R4
        {8'd1,   24'd249,  32'd0},    // R5
        {8'd1,   24'd520,  32'd2},    // R5
        {8'd2,   24'd1000, 32'd0},    // R6
        {8'd5,   24'd300,  32'd0},    // R7
        {8'd255, 24'd10,   32'd0}     // R7
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd_m(input logic [11:0] a, output logic [31:0] v);
        bus_addr = a;
        #0.5;
        v = rdata_m;
    endtask

    task automatic rd_s(input logic [11:0] a, output logic [31:0] v);
        bus_addr = a;
        #0.5;
        v = rdata_s;
    endtask

    task automatic zero_seq(input logic [7:0] src);
        wr(A_CFG, {23'd0, 1'b1, src});
        wr(A_CFG, {24'd0, src});
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rd_m(A_CFG, v); chk("R1 cfg in reset", v, 32'd0);
        rd_m(A_CNT, v); chk("R1 count in reset", v, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        wait_cyc(10);
        rd_m(A_CNT, v); chk("R1 ns run after reset", v, 32'd40);

        for (int i = 0; i < NV; i++) begin
            zero_seq(VECS[i][63:56]);
            wait_cyc(int'(VECS[i][55:32]));
            rd_m(A_CNT, v); chk($sformatf("R4/R5/R6/R7 vec %0d count", i), v, VECS[i][31:0]);
            rd_m(A_CFG, v); chk($sformatf("R7 vec %0d cfg readback", i), v, {24'd0, VECS[i][63:56]});
        end

        // R3: hold while clear bit set
        wr(A_CFG, 32'h101);
        wait_cyc(600);
        rd_m(A_CNT, v); chk("R3 held count", v, 32'd0);
        rd_m(A_CFG, v); chk("R3 cfg with clear bit", v, 32'h101);
        wr(A_CFG, 32'h001);
        wait_cyc(250);
        rd_m(A_CNT, v); chk("R3 resume from zero", v, 32'd1);

        // R8: rewrite same source restarts prescaler
        zero_seq(8'd1);
        wait_cyc(200);
        wr(A_CFG, 32'h001);
        wait_cyc(249);
        rd_m(A_CNT, v); chk("R8 no early tick", v, 32'd0);
        wait_cyc(1);
        rd_m(A_CNT, v); chk("R8 tick one period later", v, 32'd1);

        // R7: freeze a running count
        zero_seq(8'd0);
        wait_cyc(10);
        wr(A_CFG, 32'h007);
        wait_cyc(100);
        rd_m(A_CNT, v); chk("R7 frozen count", v, 32'd40);

        // R9: count register is read-only
        wr(A_CNT, 32'h1234_5678);
        rd_m(A_CNT, v); chk("R9 count unchanged", v, 32'd40);
        rd_m(A_CFG, v); chk("R9 cfg unchanged", v, 32'd7);

        // R2: upper bits and unmapped address
        wr(A_CFG, 32'hFFFF_FE01);
        rd_m(A_CFG, v); chk("R2 upper bits zero", v, 32'h001);
        rd_m(12'h604, v); chk("R2 unmapped reads zero", v, 32'd0);

        // R10: wrap on 8-bit small instance (ns step every cycle)
        zero_seq(8'd0);
        wait_cyc(13);
        rd_s(A_CNT, v); chk("R10 wrap mod 256", v, 32'd4);

        // R6: ms rate on small instance (50000 cycles per ms)
        zero_seq(8'd2);
        wait_cyc(49999);
        rd_s(A_CNT, v); chk("R6 ms before period", v, 32'd0);
        wait_cyc(1);
        rd_s(A_CNT, v); chk("R6 ms after period", v, 32'd1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(190000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule